// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block produces the bus-level timing for single NAND flash read and write cycles. A host presents one request at a time: a direction, a flag that marks a command cycle, and the write data. The block then drives the active-low chip enable and the active-low read or write strobe. It captures read data and enforces a turnaround gap before it takes the next request. After a command write, it hides the device ready/busy pin for a programmed interval.

Every interval is a cycle count taken from one packed 32-bit timing word. The read strobe and the write strobe each have their own low and high phase lengths. The clock-rate arithmetic that produces the field values, command and address sequencing, error correction and data buffering all live outside this block.

Top module: `nand_strobe_timer`

## Requirements
- R1: The timing word packs seven counts: write-strobe low in bits 3:0, write-strobe high in bits 7:4, read-strobe low in bits 11:8, read-strobe high in bits 15:12, turnaround in bits 18:16, busy delay in bits 23:19 and enable lead in bits 25:24. A value N means N clock cycles, and a value of 0 means 1 cycle. Bits 31:26 are ignored.
- R2: After a request is accepted, ce_n goes low in the next cycle and stays low for the enable-lead count before the strobe falls. It stays low through the strobe's low and high phases, and it rises in the cycle after the high phase ends.
- R3: req_write = 1 selects a write, which pulses we_n low for the write-low count and then high for the write-high count. req_write = 0 selects a read, which does the same on re_n with the read counts. The other strobe stays high.
- R4: On a read, rdata takes dq_in as sampled on the last cycle of the re_n low phase. rdata holds that value until the next read captures a new one, so writes leave it unchanged.
- R5: During a write, dq_oe is 1 and dq_out carries the request's data from the first cycle of ce_n low through the last cycle of the high phase. On reads, dq_oe stays 0.
- R6: done is 1 for exactly one cycle, the cycle right after the strobe's high phase ends.
- R7: req_ready is 0 from the cycle after acceptance until the turnaround count has elapsed, counting from the done cycle. It returns to 1 the turnaround count of cycles after the done cycle.
- R8: The timing word is sampled in the accept cycle. Changing it during an access has no effect on that access.
- R9: A write with req_cmd = 1 forces dev_ready to 0 for the busy-delay count of cycles, starting with its done cycle. Reads and writes without req_cmd do not.
- R10: Outside that window, dev_ready equals rb_n delayed by one register stage, where 1 means the device is ready.
- R11: In reset, ce_n, re_n and we_n are 1, done and dq_oe are 0, req_ready is 1 and dev_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timing_word | input | 32 | Packed cycle counts (R1) |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cmd | input | 1 | Marks a command write that opens the busy window |
| req_wdata | input | 8 | Data driven during a write |
| req_ready | output | 1 | Block can accept a request this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last captured read data |
| ce_n | output | 1 | Active-low chip enable |
| re_n | output | 1 | Active-low read strobe |
| we_n | output | 1 | Active-low write strobe |
| dq_out | output | 8 | Write data to the bus |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | 8 | Read data from the bus |
| rb_n | input | 1 | Device ready/busy pin, 1 = ready |
| dev_ready | output | 1 | Gated, registered ready indication |

## Verification
Counting from the first cycle after the accept edge as cycle 0, with lead C, low L, high H, turnaround T and busy B: the strobe is low in cycles C to C+L-1, done is high in cycle C+L+H, req_ready returns in cycle C+L+H+T, and the busy window covers cycles C+L+H to C+L+H+B-1. Each access task computes these indices from the word it programmed and compares every output on every cycle at the falling clock edge, so an off-by-one in any phase shows up as a mismatch in that exact cycle. Read data is checked after the access, with dq_in changed every cycle of the low phase so that only the last-cycle value can match. The pin-to-dev_ready latency is checked as one register stage.

// File: rtl/nst_pkg.sv
// Shared types for the NAND strobe timing generator.
// Assumes the timing word layout is fixed by the bus-timing contract (R1).
package nst_pkg;
    localparam int TW_W   = 32;
    localparam int CNT_W  = 5;
    localparam int USED_W = 24;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t wr_lo;
        cnt_t wr_hi;
        cnt_t rd_lo;
        cnt_t rd_hi;
        cnt_t turn;
        cnt_t busy;
    } tcfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_TURN
    } phase_t;

    // Clamp a zero count up to one cycle.
    function automatic cnt_t at_least_one(input cnt_t v);
        return (v == '0) ? cnt_t'(1) : v;
    endfunction

    // Split the lower part of the timing word into clamped counts.
    function automatic tcfg_t unpack_timing(input logic [USED_W-1:0] w);
        tcfg_t c;
        c.wr_lo = at_least_one(cnt_t'(w[3:0]));
        c.wr_hi = at_least_one(cnt_t'(w[7:4]));
        c.rd_lo = at_least_one(cnt_t'(w[11:8]));
        c.rd_hi = at_least_one(cnt_t'(w[15:12]));
        c.turn  = at_least_one(cnt_t'(w[18:16]));
        c.busy  = at_least_one(cnt_t'(w[23:19]));
        return c;
    endfunction
endpackage

// File: rtl/nst_timing_latch.sv
// Holds the decoded timing counts for the access in flight.
// Assumes capture is high only in the cycle a request is accepted (R8).
module nst_timing_latch
    import nst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [USED_W-1:0] word,
    output tcfg_t             cfg
);

    // Register the decoded counts when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= unpack_timing('0);
        end else if (capture) begin
            cfg <= unpack_timing(word);
        end
    end

endmodule

// File: rtl/nst_phase_seq.sv
// Phase sequencer: lead, strobe low, strobe high, turnaround.
// Assumes the count inputs are already clamped to at least one and are
// stable from the cycle after acceptance until the access ends.
module nst_phase_seq
    import nst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_cmd,
    input  logic [DATA_W-1:0] req_wdata,
    input  cnt_t              lead_cnt,
    input  cnt_t              wr_lo,
    input  cnt_t              wr_hi,
    input  cnt_t              rd_lo,
    input  cnt_t              rd_hi,
    input  cnt_t              turn,
    input  logic [DATA_W-1:0] dq_in,
    output logic              req_ready,
    output logic              accept,
    output logic              done,
    output logic              cmd_done,
    output logic [DATA_W-1:0] rdata,
    output logic              ce_n,
    output logic              re_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    phase_t            ph;
    cnt_t              cnt;
    logic              wr_q;
    logic              cmd_q;
    logic [DATA_W-1:0] wd_q;
    logic              last;
    logic              in_access;
    logic              high_end;

    assign last      = (cnt == cnt_t'(1));
    assign req_ready = (ph == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign in_access = (ph == PH_LEAD) || (ph == PH_LOW) || (ph == PH_HIGH);
    assign high_end  = (ph == PH_HIGH) && last;

    // Advance the phase and reload the cycle counter at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= cnt_t'(1);
        end else begin
            case (ph)
                PH_IDLE: if (accept) begin
                    ph  <= PH_LEAD;
                    cnt <= lead_cnt;
                end
                PH_LEAD: if (last) begin
                    ph  <= PH_LOW;
                    cnt <= wr_q ? wr_lo : rd_lo;
                end else begin
                    cnt <= cnt - cnt_t'(1);
                end
                PH_LOW: if (last) begin
                    ph  <= PH_HIGH;
                    cnt <= wr_q ? wr_hi : rd_hi;
                end else begin
                    cnt <= cnt - cnt_t'(1);
                end
                PH_HIGH: if (last) begin
                    ph  <= PH_TURN;
                    cnt <= turn;
                end else begin
                    cnt <= cnt - cnt_t'(1);
                end
                PH_TURN: if (last) begin
                    ph <= PH_IDLE;
                end else begin
                    cnt <= cnt - cnt_t'(1);
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Hold the request attributes for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            cmd_q <= 1'b0;
            wd_q  <= '0;
        end else if (accept) begin
            wr_q  <= req_write;
            cmd_q <= req_cmd;
            wd_q  <= req_wdata;
        end
    end

    // Produce the one-cycle completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            cmd_done <= 1'b0;
        end else begin
            done     <= high_end;
            cmd_done <= high_end && wr_q && cmd_q;
        end
    end

    // Capture read data on the final cycle of the read-strobe low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if ((ph == PH_LOW) && last && !wr_q) begin
            rdata <= dq_in;
        end
    end

    assign ce_n   = !in_access;
    assign re_n   = !((ph == PH_LOW) && !wr_q);
    assign we_n   = !((ph == PH_LOW) && wr_q);
    assign dq_oe  = in_access && wr_q;
    assign dq_out = wd_q;

    a_r2_strobe_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!re_n || !we_n) |-> !ce_n);

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!re_n && !we_n));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_busy_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    a_r4_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (re_n && $past(re_n)) |-> $stable(rdata));

endmodule

// File: rtl/nst_busy_gate.sv
// Registers the ready/busy pin and masks it after a command write.
// Assumes busy_len is clamped to at least one and stable while cmd_done is high.
module nst_busy_gate
    import nst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_done,
    input  cnt_t busy_len,
    input  logic rb_n,
    output logic dev_ready
);

    cnt_t hold_cnt;
    logic rb_q;

    // Count down the remaining masked cycles after a command completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (cmd_done) begin
            hold_cnt <= busy_len - cnt_t'(1);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - cnt_t'(1);
        end
    end

    // Bring the ready/busy pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_q <= 1'b0;
        end else begin
            rb_q <= rb_n;
        end
    end

    assign dev_ready = rb_q && !cmd_done && (hold_cnt == '0);

    a_r10_ready_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ready |-> $past(rb_n));

    a_r9_mask_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_done) && ($past(busy_len) > cnt_t'(1))) |-> !dev_ready);

endmodule

// File: rtl/nand_strobe_timer.sv
// Top level: single-cycle NAND strobe timing generator.
// Assumes one request at a time and a timing word valid in the accept cycle.
module nand_strobe_timer
    import nst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW_W-1:0]   timing_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_cmd,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ce_n,
    output logic              re_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              rb_n,
    output logic              dev_ready
);

    localparam int LEAD_LSB = USED_W;

    tcfg_t cfg;
    cnt_t  lead_live;
    logic  accept;
    logic  cmd_done;
    logic  unused_tw;

    assign lead_live = at_least_one(cnt_t'(timing_word[LEAD_LSB+1:LEAD_LSB]));
    assign unused_tw = ^timing_word[TW_W-1:LEAD_LSB+2];

    nst_timing_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .word    (timing_word[USED_W-1:0]),
        .cfg     (cfg)
    );

    nst_phase_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cmd   (req_cmd),
        .req_wdata (req_wdata),
        .lead_cnt  (lead_live),
        .wr_lo     (cfg.wr_lo),
        .wr_hi     (cfg.wr_hi),
        .rd_lo     (cfg.rd_lo),
        .rd_hi     (cfg.rd_hi),
        .turn      (cfg.turn),
        .dq_in     (dq_in),
        .req_ready (req_ready),
        .accept    (accept),
        .done      (done),
        .cmd_done  (cmd_done),
        .rdata     (rdata),
        .ce_n      (ce_n),
        .re_n      (re_n),
        .we_n      (we_n),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    nst_busy_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_done  (cmd_done),
        .busy_len  (cfg.busy),
        .rb_n      (rb_n),
        .dev_ready (dev_ready)
    );

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && re_n && we_n && !dq_oe));

endmodule

// File: tb/sim_nand_strobe_timer.sv
module sim_nand_strobe_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_word = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_cmd = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, ce_n, re_n, we_n, dq_oe, dev_ready;
    logic [7:0]  rdata, dq_out;
    logic [7:0]  dq_in = 8'hA5;
    logic        rb_n = 1'b1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [7:0] last_rd = 8'h00;

    always #10 clk = ~clk;

    nand_strobe_timer u0 (
        .clk(clk), .rst_n(rst_n), .timing_word(timing_word),
        .req_valid(req_valid), .req_write(req_write), .req_cmd(req_cmd),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .rdata(rdata), .ce_n(ce_n), .re_n(re_n), .we_n(we_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb_n(rb_n),
        .dev_ready(dev_ready)
    );

    function automatic int fld(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // R11: outputs while reset is held and right after release.
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({ce_n, re_n, we_n, done, dq_oe, req_ready, dev_ready} == 7'b1110010,
              "R11 reset outputs", {ce_n, re_n, we_n, done, dq_oe, req_ready, dev_ready}, 7'b1110010);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(req_ready && ce_n && dev_ready, "R11 R10 after release",
              {req_ready, ce_n, dev_ready}, 3'b111);
    endtask

    // R1-R9 in one access: per-cycle comparison of every output.
    task automatic run_access(input bit wr, input bit cmd, input logic [31:0] tw,
                              input logic [7:0] wd, input logic [7:0] rbase);
        int c, l, h, t, b, total;
        c = fld(int'(tw[25:24]));
        l = wr ? fld(int'(tw[3:0]))  : fld(int'(tw[11:8]));
        h = wr ? fld(int'(tw[7:4]))  : fld(int'(tw[15:12]));
        t = fld(int'(tw[18:16]));
        b = fld(int'(tw[23:19]));
        total = c + l + h + ((t > b) ? t : b) + 1;
        @(negedge clk);
        timing_word = tw;
        req_valid = 1'b1;
        req_write = wr;
        req_cmd = cmd;
        req_wdata = wd;
        check(req_ready, "R7 ready before request", {31'b0, req_ready}, 1);
        @(negedge clk);
        req_valid = 1'b0;
        timing_word = ~tw;   // R8: must not disturb this access
        req_wdata = ~wd;
        for (int j = 0; j < total; j++) begin
            bit low, act, busy_win;
            logic [15:0] got, exp;
            low = (j >= c) && (j < c + l);
            act = (j < c + l + h);
            busy_win = wr && cmd && (j >= c + l + h) && (j < c + l + h + b);
            dq_in = (!wr && low) ? rbase + 8'(j - c) : 8'hA5;
            got = {ce_n, re_n, we_n, done, req_ready, dq_oe, dev_ready,
                   (dq_oe ? dq_out : 8'h00), 1'b0};
            exp = {!act, !(low && !wr), !(low && wr), (j == c + l + h),
                   (j >= c + l + h + t), (wr && act), !busy_win,
                   ((wr && act) ? wd : 8'h00), 1'b0};
            check(got == exp, "R1 R2 R3 R5 R6 R7 R8 R9 cycle", {16'b0, got}, {16'b0, exp});
            @(negedge clk);
        end
        dq_in = 8'hA5;
        if (!wr) begin
            last_rd = rbase + 8'(l - 1);
            check(rdata == last_rd, "R4 read capture", {24'b0, rdata}, {24'b0, last_rd});
        end else begin
            check(rdata == last_rd, "R4 rdata held over write", {24'b0, rdata}, {24'b0, last_rd});
        end
    endtask

    // R10: pin-to-output latency of one register stage.
    task automatic test_rb_gate();
        @(negedge clk);
        rb_n = 1'b0;
        check(dev_ready == 1'b1, "R10 pre-edge value", {31'b0, dev_ready}, 1);
        @(negedge clk);
        check(dev_ready == 1'b0, "R10 busy follows pin", {31'b0, dev_ready}, 0);
        @(negedge clk);
        rb_n = 1'b1;
        check(dev_ready == 1'b0, "R10 still busy", {31'b0, dev_ready}, 0);
        @(negedge clk);
        check(dev_ready == 1'b1, "R10 ready follows pin", {31'b0, dev_ready}, 1);
    endtask

    localparam logic [31:0] TW_MID = (32'd2 << 24) | (32'd5 << 19) | (32'd2 << 16) |
                                     (32'd1 << 12) | (32'd4 << 8) | (32'd2 << 4) | 32'd3;

    initial begin
        test_reset();
        run_access(1'b1, 1'b0, TW_MID, 8'h3C, 8'h10);            // R3 write timing
        run_access(1'b0, 1'b0, TW_MID, 8'h00, 8'h20);            // R4 read timing
        run_access(1'b1, 1'b1, TW_MID, 8'hC3, 8'h00);            // R9 command write
        run_access(1'b0, 1'b1, TW_MID, 8'h00, 8'h40);            // R9 no mask on read
        run_access(1'b0, 1'b0, 32'h0000_0000, 8'h00, 8'h50);     // R1 zero fields
        run_access(1'b1, 1'b1, 32'hFC00_0000, 8'h81, 8'h00);     // R1 zeros, ignored high bits
        run_access(1'b0, 1'b0, 32'hFFFF_FFFF, 8'h00, 8'h60);     // R1 maximum read
        run_access(1'b1, 1'b1, 32'h03FF_FFFF, 8'h7E, 8'h00);     // R1 maximum command write
        run_access(1'b1, 1'b0, 32'h0001_2F1F, 8'h99, 8'h00);     // R3 asymmetric write
        test_rb_gate();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule